// File: doc/BRIEF.md
# SD Host Bus-Mode Control Register

This block is the 16-bit mode-control register of an SD/SDIO host controller. Software reaches it through a simple register bus as a single word at byte offset 0x3E. It holds a preset enable, an asynchronous-interrupt enable, the tuning start bit, the tuning result, a driver strength field, the 1.8 V signaling enable and a three-bit bus-speed code.

The clock-divider, clock-generator and driver-strength values the rest of the host uses come out of this block. They come either from fields that software wrote or from one of several preset words, and the speed code picks that word. The block also runs the handshake with an external tuning engine: start, abort, completion with a pass/fail result, and a reset pulse for the tuning circuit. It times each signaling-voltage change against a programmable limit and flags a regulator that does not settle in time.

Top module: `sd_mode_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0x0000, and `tune_start`, `tune_abort`, `tune_rst`, `vsw_busy`, `vsw_timeout` and `vs18_en` are all 0.
- R2: A write with `reg_addr` equal to `REG_OFFSET` (default 0x3E) updates the register, and a write to any other address leaves it unchanged. The read word is {bit15 preset enable, bit14 async interrupt enable, bits13:8 zero, bit7 sampling-clock select, bit6 execute tuning, bits5:4 driver strength, bit3 1.8 V enable, bits2:0 speed code}.
- R3: With preset enable 0, `eff_fsel` and `eff_cgsel` follow `user_fsel` and `user_cgsel`, and the driver strength comes from register bits 5:4. The effective outputs lag their sources by one clock.
- R4: With preset enable 1, `eff_fsel`, `eff_cgsel` and `eff_drv` come from the selected 16-bit preset word. Preset word k sits at `preset_words[16k+15:16k]` and is laid out as {drv[1:0] at 15:14, clock-generator select at 13, frequency select at 12:0}.
- R5: Speed codes are 0 SDR12, 1 SDR25, 2 SDR50, 3 SDR104 and 4 DDR50. The code is in force only while 1.8 V enable is 1 and `ddr_mode` is 0. Otherwise `uhs_eff` is 0 and preset word 0 is used. Codes 5 to 7 select preset word 0.
- R6: Driver strength codes are 0 type B, 1 type A, 2 type C and 3 type D. While 1.8 V enable is 0, `eff_drv` is 0 (type B) whatever its source.
- R7: Writing 1 to execute tuning while it is 0 sets it, pulses `tune_start` for one clock and clears sampling-clock select.
- R8: A `tune_done` pulse while execute tuning is 1 clears execute tuning and loads sampling-clock select with `tune_pass`. A `tune_done` pulse while execute tuning is 0 has no effect.
- R9: Writing 0 to execute tuning while it is 1 clears it and pulses `tune_abort` for one clock.
- R10: Writing 1 to sampling-clock select never sets it. Writing 0 while it is 1 clears it and pulses `tune_rst` for one clock.
- R11: While `rx_busy` is 1, a write leaves sampling-clock select unchanged and produces no `tune_rst`.
- R12: A write that changes 1.8 V enable raises `vsw_busy` one clock later. `vsw_busy` clears once `vreg_stable` is seen high.
- R13: If `vreg_stable` stays low for `SWITCH_CYCLES` clocks after the change, `vsw_busy` clears and `vsw_timeout` sets. `vsw_timeout` stays set until the next change of 1.8 V enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Register read value |
| user_fsel | input | 13 | Software frequency select |
| user_cgsel | input | 1 | Software clock-generator select |
| ddr_mode | input | 1 | DDR mode control; 1 suppresses the speed code |
| preset_words | input | 16*NUM_PRESET | Packed preset words |
| rx_busy | input | 1 | Response or read block being received |
| tune_done | input | 1 | Tuning engine completion pulse |
| tune_pass | input | 1 | Tuning result, valid with tune_done |
| tune_start | output | 1 | One-clock tuning start pulse |
| tune_abort | output | 1 | One-clock tuning abort pulse |
| tune_rst | output | 1 | One-clock tuning-circuit reset pulse |
| vreg_stable | input | 1 | Regulator reports stable output |
| vs18_en | output | 1 | 1.8 V signaling request to the regulator |
| vsw_busy | output | 1 | Voltage switch in progress |
| vsw_timeout | output | 1 | Regulator failed to settle in time |
| eff_fsel | output | 13 | Effective frequency select |
| eff_cgsel | output | 1 | Effective clock-generator select |
| eff_drv | output | 2 | Effective driver strength |
| uhs_eff | output | 3 | Speed code in force |

## Verification
The hardest state to reach is sampling-clock select at 1, because no register write can set it. Only a completion report from the tuning engine carrying a pass result sets it. The stimulus therefore runs a full start/complete handshake with `tune_pass` high before each check of clearing, blocking under `rx_busy`, or ignored writes of 1. A later handshake with a fail result drives the bit back to 0. The timeout path needs the regulator-stable input held low across the whole window, so the bench shrinks `SWITCH_CYCLES` and measures the window from the clock on which the write lands.

// File: rtl/sd_mode_pkg.sv
package sd_mode_pkg;
  localparam int REG_W   = 16;
  localparam int FSEL_W  = 13;
  localparam int DRV_W   = 2;
  localparam int MODE_W  = 3;

  localparam int B_PVEN  = 15;
  localparam int B_AINT  = 14;
  localparam int B_SCLK  = 7;
  localparam int B_EXEC  = 6;
  localparam int B_DRVLO = 4;
  localparam int B_VS18  = 3;
  localparam int B_MODE  = 0;

  typedef enum logic [DRV_W-1:0] {
    DRV_B = 2'd0,
    DRV_A = 2'd1,
    DRV_C = 2'd2,
    DRV_D = 2'd3
  } drv_e;

  typedef struct packed {
    logic [DRV_W-1:0]  drv;
    logic              cgsel;
    logic [FSEL_W-1:0] fsel;
  } preset_word_t;
endpackage

// File: rtl/sd_preset_mux.sv
module sd_preset_mux
  import sd_mode_pkg::*;
#(
  parameter int NUM_PRESET = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        pv_en,
  input  logic                        vs18,
  input  logic                        ddr_mode,
  input  logic [MODE_W-1:0]           mode,
  input  logic [DRV_W-1:0]            user_drv,
  input  logic [FSEL_W-1:0]           user_fsel,
  input  logic                        user_cgsel,
  input  logic [NUM_PRESET*REG_W-1:0] preset_words,
  output logic [FSEL_W-1:0]           eff_fsel,
  output logic                        eff_cgsel,
  output logic [DRV_W-1:0]            eff_drv,
  output logic [MODE_W-1:0]           uhs_eff
);
  preset_word_t words [NUM_PRESET];

  generate
    for (genvar g = 0; g < NUM_PRESET; g++) begin : g_unpack
      assign words[g] = preset_word_t'(preset_words[g*REG_W +: REG_W]);
    end
  endgenerate

  logic         mode_ok;
  preset_word_t pick;
  logic [FSEL_W-1:0] nxt_fsel;
  logic              nxt_cg;
  logic [DRV_W-1:0]  nxt_drv;

  assign mode_ok = vs18 && !ddr_mode;

  always_comb begin
    pick = words[0];
    for (int k = 1; k < NUM_PRESET; k++) begin
      if (mode_ok && mode == MODE_W'(k)) pick = words[k];
    end
  end

  always_comb begin
    if (pv_en) begin
      nxt_fsel = pick.fsel;
      nxt_cg   = pick.cgsel;
      nxt_drv  = pick.drv;
    end else begin
      nxt_fsel = user_fsel;
      nxt_cg   = user_cgsel;
      nxt_drv  = user_drv;
    end
    if (!vs18) nxt_drv = DRV_B;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_fsel  <= '0;
      eff_cgsel <= 1'b0;
      eff_drv   <= DRV_B;
      uhs_eff   <= '0;
    end else begin
      eff_fsel  <= nxt_fsel;
      eff_cgsel <= nxt_cg;
      eff_drv   <= nxt_drv;
      uhs_eff   <= mode_ok ? mode : '0;
    end
  end

  p_drv_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !vs18 |=> (eff_drv == DRV_B));

  p_mode_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (!vs18 || ddr_mode) |=> (uhs_eff == '0));

  p_user_path_r3: assert property (@(posedge clk) disable iff (rst)
    !pv_en |=> (eff_fsel == $past(user_fsel) && eff_cgsel == $past(user_cgsel)));
endmodule

// File: rtl/sd_tune_ctrl.sv
module sd_tune_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_exec,
  input  logic wr_sclk,
  input  logic rx_busy,
  input  logic tune_done,
  input  logic tune_pass,
  output logic exec_q,
  output logic sclk_q,
  output logic tune_start,
  output logic tune_abort,
  output logic tune_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q     <= 1'b0;
      sclk_q     <= 1'b0;
      tune_start <= 1'b0;
      tune_abort <= 1'b0;
      tune_rst   <= 1'b0;
    end else begin
      tune_start <= 1'b0;
      tune_abort <= 1'b0;
      tune_rst   <= 1'b0;
      if (wr) begin
        if (wr_exec && !exec_q) begin
          exec_q     <= 1'b1;
          tune_start <= 1'b1;
          if (!rx_busy) sclk_q <= 1'b0;
        end else if (!wr_exec && exec_q) begin
          exec_q     <= 1'b0;
          tune_abort <= 1'b1;
        end
        if (!wr_sclk && sclk_q && !rx_busy) begin
          sclk_q   <= 1'b0;
          tune_rst <= 1'b1;
        end
      end else if (tune_done && exec_q) begin
        exec_q <= 1'b0;
        sclk_q <= tune_pass;
      end
    end
  end

  p_start_sets_exec_r7: assert property (@(posedge clk) disable iff (rst)
    tune_start |-> exec_q);

  p_done_result_r8: assert property (@(posedge clk) disable iff (rst)
    (tune_done && exec_q && !wr) |=> (!exec_q && sclk_q == $past(tune_pass)));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (rst)
    tune_abort |-> !exec_q);

  p_sclk_no_write_set_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_q) |-> $past(tune_done && !wr));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (wr && rx_busy) |=> (sclk_q == $past(sclk_q) && !tune_rst));
endmodule

// File: rtl/sd_vswitch_timer.sv
module sd_vswitch_timer #(
  parameter int SWITCH_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic vreg_stable,
  output logic busy,
  output logic timeout
);
  localparam int CNT_W = $clog2(SWITCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SWITCH_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      timeout <= 1'b0;
      cnt     <= '0;
    end else if (kick) begin
      busy    <= 1'b1;
      timeout <= 1'b0;
      cnt     <= '0;
    end else if (busy) begin
      if (vreg_stable) begin
        busy <= 1'b0;
      end else if (cnt == LAST) begin
        busy    <= 1'b0;
        timeout <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_kick_busy_r12: assert property (@(posedge clk) disable iff (rst)
    kick |=> busy);

  p_timeout_source_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> $past(busy && !vreg_stable));

  p_timeout_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(busy && timeout));
endmodule

// File: rtl/sd_mode_ctrl.sv
module sd_mode_ctrl
  import sd_mode_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET    = 8'h3E,
  parameter int                NUM_PRESET    = 5,
  parameter int                SWITCH_CYCLES = 1_000_000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  input  logic [FSEL_W-1:0]           user_fsel,
  input  logic                        user_cgsel,
  input  logic                        ddr_mode,
  input  logic [NUM_PRESET*REG_W-1:0] preset_words,
  input  logic                        rx_busy,
  input  logic                        tune_done,
  input  logic                        tune_pass,
  output logic                        tune_start,
  output logic                        tune_abort,
  output logic                        tune_rst,
  input  logic                        vreg_stable,
  output logic                        vs18_en,
  output logic                        vsw_busy,
  output logic                        vsw_timeout,
  output logic [FSEL_W-1:0]           eff_fsel,
  output logic                        eff_cgsel,
  output logic [DRV_W-1:0]            eff_drv,
  output logic [MODE_W-1:0]           uhs_eff
);
  logic              wr_hit;
  logic              pv_en_q;
  logic              aint_q;
  logic [DRV_W-1:0]  drv_q;
  logic              vs18_q;
  logic [MODE_W-1:0] mode_q;
  logic              exec_q;
  logic              sclk_q;
  logic              kick;
  logic              unused_rsvd;

  assign wr_hit      = reg_wr && (reg_addr == REG_OFFSET);
  assign kick        = wr_hit && (reg_wdata[B_VS18] != vs18_q);
  assign unused_rsvd = ^reg_wdata[13:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_en_q <= 1'b0;
      aint_q  <= 1'b0;
      drv_q   <= DRV_B;
      vs18_q  <= 1'b0;
      mode_q  <= '0;
    end else if (wr_hit) begin
      pv_en_q <= reg_wdata[B_PVEN];
      aint_q  <= reg_wdata[B_AINT];
      drv_q   <= reg_wdata[B_DRVLO +: DRV_W];
      vs18_q  <= reg_wdata[B_VS18];
      mode_q  <= reg_wdata[B_MODE +: MODE_W];
    end
  end

  assign reg_rdata = {pv_en_q, aint_q, 6'b000000, sclk_q, exec_q, drv_q, vs18_q, mode_q};
  assign vs18_en   = vs18_q;

  sd_tune_ctrl i_tune (
    .clk        (clk),
    .rst        (rst),
    .wr         (wr_hit),
    .wr_exec    (reg_wdata[B_EXEC]),
    .wr_sclk    (reg_wdata[B_SCLK]),
    .rx_busy    (rx_busy),
    .tune_done  (tune_done),
    .tune_pass  (tune_pass),
    .exec_q     (exec_q),
    .sclk_q     (sclk_q),
    .tune_start (tune_start),
    .tune_abort (tune_abort),
    .tune_rst   (tune_rst)
  );

  sd_preset_mux #(.NUM_PRESET(NUM_PRESET)) i_mux (
    .clk          (clk),
    .rst          (rst),
    .pv_en        (pv_en_q),
    .vs18         (vs18_q),
    .ddr_mode     (ddr_mode),
    .mode         (mode_q),
    .user_drv     (drv_q),
    .user_fsel    (user_fsel),
    .user_cgsel   (user_cgsel),
    .preset_words (preset_words),
    .eff_fsel     (eff_fsel),
    .eff_cgsel    (eff_cgsel),
    .eff_drv      (eff_drv),
    .uhs_eff      (uhs_eff)
  );

  sd_vswitch_timer #(.SWITCH_CYCLES(SWITCH_CYCLES)) i_vsw (
    .clk         (clk),
    .rst         (rst),
    .kick        (kick),
    .vreg_stable (vreg_stable),
    .busy        (vsw_busy),
    .timeout     (vsw_timeout)
  );

  p_addr_miss_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> (pv_en_q == $past(pv_en_q) && mode_q == $past(mode_q)
                 && vs18_q == $past(vs18_q) && drv_q == $past(drv_q)));
endmodule

// File: tb/test_sd_mode_ctrl.sv
module test_sd_mode_ctrl;
  localparam int NP    = 5;
  localparam int LIMIT = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic [12:0] user_fsel = 13'h0;
  logic        user_cgsel = 1'b0;
  logic        ddr_mode = 1'b0;
  logic [NP*16-1:0] preset_words;
  logic        rx_busy = 1'b0;
  logic        tune_done = 1'b0;
  logic        tune_pass = 1'b0;
  logic        tune_start, tune_abort, tune_rst;
  logic        vreg_stable = 1'b0;
  logic        vs18_en, vsw_busy, vsw_timeout;
  logic [12:0] eff_fsel;
  logic        eff_cgsel;
  logic [1:0]  eff_drv;
  logic [2:0]  uhs_eff;

  always #2.5 clk = ~clk;

  sd_mode_ctrl #(.NUM_PRESET(NP), .SWITCH_CYCLES(LIMIT)) i_sd_mode_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .user_fsel(user_fsel),
    .user_cgsel(user_cgsel), .ddr_mode(ddr_mode), .preset_words(preset_words),
    .rx_busy(rx_busy), .tune_done(tune_done), .tune_pass(tune_pass),
    .tune_start(tune_start), .tune_abort(tune_abort), .tune_rst(tune_rst),
    .vreg_stable(vreg_stable), .vs18_en(vs18_en), .vsw_busy(vsw_busy),
    .vsw_timeout(vsw_timeout), .eff_fsel(eff_fsel), .eff_cgsel(eff_cgsel),
    .eff_drv(eff_drv), .uhs_eff(uhs_eff)
  );

  // Preset word k: drv=(k+1)%4 at 15:14, cgsel=k[0] at 13, fsel=37k+5 at 12:0
  function automatic logic [15:0] pword(int k);
    logic [1:0] d;
    d = 2'((k + 1) % 4);
    return {d, 1'(k % 2), 13'(37 * k + 5)};
  endfunction

  initial begin
    for (int k = 0; k < NP; k++) preset_words[k*16 +: 16] = pword(k);
  end

  typedef enum int {
    S_RDATA, S_FSEL, S_CG, S_DRV, S_UHS, S_START, S_ABORT, S_TRST,
    S_BUSY, S_TOUT, S_VS18
  } sel_e;

  typedef struct {
    string       req;
    sel_e        sel;
    logic [15:0] exp;
  } item_t;

  item_t sb_q[$];
  event  sb_ev;
  int    checks = 0;
  int    fails  = 0;
  bit    finished = 0;

  function automatic logic [15:0] observe(sel_e s);
    case (s)
      S_RDATA: return reg_rdata;
      S_FSEL:  return 16'(eff_fsel);
      S_CG:    return 16'(eff_cgsel);
      S_DRV:   return 16'(eff_drv);
      S_UHS:   return 16'(uhs_eff);
      S_START: return 16'(tune_start);
      S_ABORT: return 16'(tune_abort);
      S_TRST:  return 16'(tune_rst);
      S_BUSY:  return 16'(vsw_busy);
      S_TOUT:  return 16'(vsw_timeout);
      default: return 16'(vs18_en);
    endcase
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s %s actual=%h expected=%h", it.req, it.sel.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, sel_e s, logic [15:0] e);
    item_t it;
    it.req = req; it.sel = s; it.exp = e;
    sb_q.push_back(it);
    ->sb_ev;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic done_pulse(logic pass);
    @(negedge clk);
    tune_done = 1'b1; tune_pass = pass;
    @(negedge clk);
    tune_done = 1'b0;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    expect_val("R1", S_RDATA, 16'h0000);
    expect_val("R1", S_START, 16'h0);
    expect_val("R1", S_BUSY, 16'h0);
    expect_val("R1", S_TOUT, 16'h0);
    expect_val("R1", S_VS18, 16'h0);
    rst = 1'b0;
    cyc(2);

    // R2 write, reserved bits read zero; R12 voltage switch starts
    wr_reg(8'h3E, 16'h7F2A);
    expect_val("R2", S_RDATA, 16'h402A);
    expect_val("R12", S_BUSY, 16'h1);
    expect_val("R12", S_VS18, 16'h1);
    wr_reg(8'h3C, 16'h0000);
    expect_val("R2", S_RDATA, 16'h402A);
    expect_val("R12", S_BUSY, 16'h1);
    vreg_stable = 1'b1;
    cyc(1);
    expect_val("R12", S_BUSY, 16'h0);
    expect_val("R12", S_TOUT, 16'h0);
    vreg_stable = 1'b0;

    // R3 user path, R5 code in force
    user_fsel = 13'h155; user_cgsel = 1'b1;
    cyc(2);
    expect_val("R3", S_FSEL, 16'h0155);
    expect_val("R3", S_CG, 16'h1);
    expect_val("R3", S_DRV, 16'h2);
    expect_val("R5", S_UHS, 16'h2);

    // R4 preset path
    wr_reg(8'h3E, 16'hC02A);
    cyc(1);
    expect_val("R4", S_FSEL, 16'(pword(2) & 16'h1FFF));
    expect_val("R4", S_CG, 16'(pword(2)[13]));
    expect_val("R4", S_DRV, 16'(pword(2)[15:14]));
    wr_reg(8'h3E, 16'hC02C);
    cyc(1);
    expect_val("R4", S_FSEL, 16'(pword(4) & 16'h1FFF));
    expect_val("R4", S_DRV, 16'(pword(4)[15:14]));
    // R5 reserved code falls back to word 0
    wr_reg(8'h3E, 16'hC02E);
    cyc(1);
    expect_val("R5", S_FSEL, 16'(pword(0) & 16'h1FFF));
    // R5 DDR control suppresses the code
    wr_reg(8'h3E, 16'hC02C);
    ddr_mode = 1'b1;
    cyc(2);
    expect_val("R5", S_UHS, 16'h0);
    expect_val("R5", S_FSEL, 16'(pword(0) & 16'h1FFF));
    ddr_mode = 1'b0;

    // R6 3.3 V forces type B and suppresses the code; R13 timeout
    wr_reg(8'h3E, 16'hC022);
    cyc(1);
    expect_val("R6", S_DRV, 16'h0);
    expect_val("R5", S_UHS, 16'h0);
    expect_val("R5", S_FSEL, 16'(pword(0) & 16'h1FFF));
    cyc(8);
    expect_val("R13", S_BUSY, 16'h1);
    expect_val("R13", S_TOUT, 16'h0);
    cyc(12);
    expect_val("R13", S_BUSY, 16'h0);
    expect_val("R13", S_TOUT, 16'h1);
    cyc(3);
    expect_val("R13", S_TOUT, 16'h1);

    // R7 start tuning (also returns to 1.8 V, clearing timeout)
    wr_reg(8'h3E, 16'h0048);
    expect_val("R7", S_START, 16'h1);
    expect_val("R7", S_RDATA, 16'h0048);
    expect_val("R13", S_TOUT, 16'h0);
    cyc(1);
    expect_val("R7", S_START, 16'h0);
    // R8 pass result
    done_pulse(1'b1);
    expect_val("R8", S_RDATA, 16'h0088);
    // R7 restart clears sampling select
    wr_reg(8'h3E, 16'h00C8);
    expect_val("R7", S_RDATA, 16'h0048);
    expect_val("R7", S_START, 16'h1);
    done_pulse(1'b1);
    expect_val("R8", S_RDATA, 16'h0088);

    // R11 receive busy blocks the clear
    rx_busy = 1'b1;
    wr_reg(8'h3E, 16'h0008);
    expect_val("R11", S_RDATA, 16'h0088);
    expect_val("R11", S_TRST, 16'h0);
    rx_busy = 1'b0;
    // R10 clear pulses reset, then a write of 1 is ignored
    wr_reg(8'h3E, 16'h0008);
    expect_val("R10", S_RDATA, 16'h0008);
    expect_val("R10", S_TRST, 16'h1);
    wr_reg(8'h3E, 16'h0088);
    expect_val("R10", S_RDATA, 16'h0008);
    expect_val("R10", S_TRST, 16'h0);

    // R8 fail result
    wr_reg(8'h3E, 16'h0048);
    done_pulse(1'b0);
    expect_val("R8", S_RDATA, 16'h0008);

    // R9 abort, then a late completion has no effect
    wr_reg(8'h3E, 16'h0048);
    wr_reg(8'h3E, 16'h0008);
    expect_val("R9", S_ABORT, 16'h1);
    expect_val("R9", S_RDATA, 16'h0008);
    done_pulse(1'b1);
    expect_val("R8", S_RDATA, 16'h0008);

    cyc(2);
    finished = 1;
    report();
  end
endmodule